// File: doc/BRIEF.md
# Latency-Gated DRAM Command Issuer

This block sits between a memory controller's sequencing state machine and the DFI command interface. The state machine offers one command at a time through a valid/ready handshake: a per-rank chip-select vector, a row/column address and a 3-bit encoded command type. The block captures the command together with a configured issue latency. It waits that many cycles, then places the command on the DFI chip-select and address outputs for exactly one cycle.

In the same cycle that the command appears on DFI, the block flags the downstream data paths. A column write raises a one-cycle write strobe for the write data driver. A column read raises a one-cycle read strobe for the read data receiver. Each strobe carries the encoded command beside it. While no command is on the bus, the outputs sit at quiet values, so the DFI side never sees stray selects.

The block accepts a new command only while it is idle. Each command therefore holds the block for its latency plus two cycles.

Top module: `cmd_issuer`

## Requirements
- R1: While reset is high and in the cycle after reset, req_ready is 1, dfi_cs_n is all ones, dfi_addr is zero, and wr_en, rd_en, wr_cmd and rd_cmd are zero.
- R2: A command is accepted at a rising edge where req_valid and req_ready are both 1. From that edge on, req_ready is 0 until the edge that ends the drive cycle, and it is 1 again after that edge.
- R3: Let L be the value of cfg_lat at the accept edge, and call that edge edge 0. The command is driven after edge L for exactly one cycle: dfi_cs_n equals the inverted req_cs and dfi_addr equals req_addr. With L = 0, the command is driven in the cycle right after acceptance.
- R4: In every cycle that is not a drive cycle, dfi_cs_n is all ones and dfi_addr is zero.
- R5: Write codes are 3'b010 (column write) and 3'b110 (masked write). For these codes, wr_en is 1 for the drive cycle only, with wr_cmd equal to the code, and rd_en stays 0.
- R6: Read codes are 3'b011 (column read) and 3'b111 (mode-register read). For these codes, rd_en is 1 for the drive cycle only, with rd_cmd equal to the code, and wr_en stays 0.
- R7: Every other code (3'b000, 3'b001, 3'b100, 3'b101) is still driven on dfi_cs_n and dfi_addr as in R3, but raises neither wr_en nor rd_en.
- R8: req_valid and the request fields are ignored while req_ready is 0. No second command reaches DFI, and the driven values are those captured at acceptance.
- R9: A change of cfg_lat after acceptance does not move the drive cycle of the command in flight.
- R10: wr_cmd is zero whenever wr_en is 0, and rd_cmd is zero whenever rd_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lat | input | LAT_W | Issue latency in cycles, sampled at acceptance |
| req_valid | input | 1 | Command offered by the state machine |
| req_ready | output | 1 | Block is idle and can take a command |
| req_cs | input | CS_W | Active-high rank select of the command |
| req_addr | input | ADDR_W | Address of the command |
| req_cmd | input | 3 | Encoded command type |
| dfi_cs_n | output | CS_W | Active-low chip select toward DFI |
| dfi_addr | output | ADDR_W | Address toward DFI |
| wr_en | output | 1 | One-cycle write strobe to the write data driver |
| wr_cmd | output | 3 | Encoded command accompanying wr_en |
| rd_en | output | 1 | One-cycle read strobe to the read data receiver |
| rd_cmd | output | 3 | Encoded command accompanying rd_en |

## Verification
The bench builds the block with its default widths: two ranks, a 14-bit address and a 4-bit latency field. With these values, every latency from 0 to the counter's maximum of 15 can be reached, so both the same-cycle-after-accept path and the longest wait through the counter are exercised. The two-rank select lets single-rank, both-rank and no-rank patterns show up on dfi_cs_n. The 3-bit command field lets all eight codes, and both members of each strobe class, be driven.

// File: rtl/cmd_issuer_pkg.sv
package cmd_issuer_pkg;

  localparam int CMD_W = 3;

  // Encoded command types. Only the column write/read classes steer the data paths.
  localparam logic [CMD_W-1:0] CMD_NOP  = 3'b000;
  localparam logic [CMD_W-1:0] CMD_ACT  = 3'b001;
  localparam logic [CMD_W-1:0] CMD_WR   = 3'b010;
  localparam logic [CMD_W-1:0] CMD_RD   = 3'b011;
  localparam logic [CMD_W-1:0] CMD_PRE  = 3'b100;
  localparam logic [CMD_W-1:0] CMD_REF  = 3'b101;
  localparam logic [CMD_W-1:0] CMD_MWR  = 3'b110;
  localparam logic [CMD_W-1:0] CMD_MRR  = 3'b111;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_DRIVE = 2'd2
  } iss_state_t;

endpackage

// File: rtl/cmd_issuer_decode.sv
module cmd_issuer_decode
  import cmd_issuer_pkg::*;
(
  input  logic [CMD_W-1:0] cmd,
  output logic             is_wr,
  output logic             is_rd
);

  always_comb begin
    is_wr = (cmd == CMD_WR) || (cmd == CMD_MWR);
    is_rd = (cmd == CMD_RD) || (cmd == CMD_MRR);
  end

  always_comb begin
    assert (!(is_wr && is_rd)) else $error("p_class_excl_r6: command decoded as both write and read");
  end

endmodule

// File: rtl/cmd_issuer_timer.sv
module cmd_issuer_timer #(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LAT_W-1:0] lat,
  output logic             last
);

  localparam logic [LAT_W-1:0] ONE = {{(LAT_W-1){1'b0}}, 1'b1};

  logic [LAT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= lat;
    end else if (cnt != '0) begin
      cnt <= cnt - ONE;
    end
  end

  assign last = (cnt == ONE);

  // R9: once loaded, the count only walks down; later latency values do not reach it
  p_count_down_r9: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - ONE));

endmodule

// File: rtl/cmd_issuer_drive.sv
module cmd_issuer_drive
  import cmd_issuer_pkg::*;
#(
  parameter int CS_W   = 2,
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [CS_W-1:0]   sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CMD_W-1:0]  cmd,
  input  logic              is_wr,
  input  logic              is_rd,
  output logic [CS_W-1:0]   cs_n_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              wr_en_q,
  output logic [CMD_W-1:0]  wr_cmd_q,
  output logic              rd_en_q,
  output logic [CMD_W-1:0]  rd_cmd_q
);

  localparam logic [CS_W-1:0] CS_QUIET = {CS_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n_q   <= CS_QUIET;
      addr_q   <= '0;
      wr_en_q  <= 1'b0;
      wr_cmd_q <= '0;
      rd_en_q  <= 1'b0;
      rd_cmd_q <= '0;
    end else if (fire) begin
      cs_n_q   <= ~sel;
      addr_q   <= addr;
      wr_en_q  <= is_wr;
      wr_cmd_q <= is_wr ? cmd : '0;
      rd_en_q  <= is_rd;
      rd_cmd_q <= is_rd ? cmd : '0;
    end else begin
      cs_n_q   <= CS_QUIET;
      addr_q   <= '0;
      wr_en_q  <= 1'b0;
      wr_cmd_q <= '0;
      rd_en_q  <= 1'b0;
      rd_cmd_q <= '0;
    end
  end

  p_wr_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en_q |=> !wr_en_q);

  p_rd_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    rd_en_q |=> !rd_en_q);

  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(wr_en_q && rd_en_q));

  p_cmd_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!wr_en_q |-> wr_cmd_q == '0) and (!rd_en_q |-> rd_cmd_q == '0));

endmodule

// File: rtl/cmd_issuer.sv
module cmd_issuer
  import cmd_issuer_pkg::*;
#(
  parameter int CS_W   = 2,
  parameter int ADDR_W = 14,
  parameter int LAT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LAT_W-1:0]  cfg_lat,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CS_W-1:0]   req_cs,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CMD_W-1:0]  req_cmd,
  output logic [CS_W-1:0]   dfi_cs_n,
  output logic [ADDR_W-1:0] dfi_addr,
  output logic              wr_en,
  output logic [CMD_W-1:0]  wr_cmd,
  output logic              rd_en,
  output logic [CMD_W-1:0]  rd_cmd
);

  iss_state_t        state, state_nxt;
  logic              accept, lat_zero, last, fire;
  logic [CS_W-1:0]   hold_cs, src_cs;
  logic [ADDR_W-1:0] hold_addr, src_addr;
  logic [CMD_W-1:0]  hold_cmd, src_cmd;
  logic              src_wr, src_rd;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign lat_zero  = (cfg_lat == '0);
  assign fire      = (accept && lat_zero) || (state == ST_WAIT && last);

  // Capture the command at acceptance; inputs are ignored while busy (R8).
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cs   <= '0;
      hold_addr <= '0;
      hold_cmd  <= '0;
    end else if (accept) begin
      hold_cs   <= req_cs;
      hold_addr <= req_addr;
      hold_cmd  <= req_cmd;
    end
  end

  // A zero latency issues straight from the request; otherwise from the held copy.
  always_comb begin
    if (state == ST_IDLE) begin
      src_cs   = req_cs;
      src_addr = req_addr;
      src_cmd  = req_cmd;
    end else begin
      src_cs   = hold_cs;
      src_addr = hold_addr;
      src_cmd  = hold_cmd;
    end
  end

  always_comb begin
    state_nxt = state;
    case (state)
      ST_IDLE:  if (accept) state_nxt = lat_zero ? ST_DRIVE : ST_WAIT;
      ST_WAIT:  if (last)   state_nxt = ST_DRIVE;
      ST_DRIVE:             state_nxt = ST_IDLE;
      default:              state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nxt;
  end

  cmd_issuer_timer #(.LAT_W(LAT_W)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (accept),
    .lat  (cfg_lat),
    .last (last)
  );

  cmd_issuer_decode u_decode (
    .cmd   (src_cmd),
    .is_wr (src_wr),
    .is_rd (src_rd)
  );

  cmd_issuer_drive #(.CS_W(CS_W), .ADDR_W(ADDR_W)) u_drive (
    .clk      (clk),
    .rst      (rst),
    .fire     (fire),
    .sel      (src_cs),
    .addr     (src_addr),
    .cmd      (src_cmd),
    .is_wr    (src_wr),
    .is_rd    (src_rd),
    .cs_n_q   (dfi_cs_n),
    .addr_q   (dfi_addr),
    .wr_en_q  (wr_en),
    .wr_cmd_q (wr_cmd),
    .rd_en_q  (rd_en),
    .rd_cmd_q (rd_cmd)
  );

  p_ready_drop_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  p_drive_one_cycle_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DRIVE) |=> (state == ST_IDLE && req_ready));

  p_strobe_in_drive_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en || rd_en) |-> (state == ST_DRIVE));

  p_quiet_when_ready_r4: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (dfi_cs_n == {CS_W{1'b1}} && dfi_addr == '0 && !wr_en && !rd_en));

endmodule

// File: tb/sim_cmd_issuer.sv
module sim_cmd_issuer;

  localparam int CLK_PERIOD = 10;
  localparam int CS_W   = 2;
  localparam int ADDR_W = 14;
  localparam int LAT_W  = 4;
  localparam int OBS_W  = 1 + CS_W + ADDR_W + 1 + 3 + 1 + 3;
  localparam int NVEC   = 10;

  // Vector layout: {cs, addr, cmd, lat}
  localparam logic [CS_W+ADDR_W+3+LAT_W-1:0] VEC [NVEC] = '{
    {2'b01, 14'h0123, 3'b010, 4'd0},
    {2'b10, 14'h3FFF, 3'b011, 4'd1},
    {2'b11, 14'h1555, 3'b110, 4'd2},
    {2'b01, 14'h2AAA, 3'b111, 4'd3},
    {2'b10, 14'h0001, 3'b001, 4'd0},
    {2'b00, 14'h0F0F, 3'b100, 4'd5},
    {2'b01, 14'h0000, 3'b101, 4'd1},
    {2'b11, 14'h1234, 3'b000, 4'd4},
    {2'b10, 14'h0ACE, 3'b010, 4'd15},
    {2'b01, 14'h3210, 3'b011, 4'd0}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [LAT_W-1:0]  cfg_lat = '0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [CS_W-1:0]   req_cs = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [2:0]        req_cmd = '0;
  logic [CS_W-1:0]   dfi_cs_n;
  logic [ADDR_W-1:0] dfi_addr;
  logic              wr_en, rd_en;
  logic [2:0]        wr_cmd, rd_cmd;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_issuer #(.CS_W(CS_W), .ADDR_W(ADDR_W), .LAT_W(LAT_W)) u0 (
    .clk(clk), .rst(rst), .cfg_lat(cfg_lat),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_cs(req_cs), .req_addr(req_addr), .req_cmd(req_cmd),
    .dfi_cs_n(dfi_cs_n), .dfi_addr(dfi_addr),
    .wr_en(wr_en), .wr_cmd(wr_cmd), .rd_en(rd_en), .rd_cmd(rd_cmd)
  );

  function automatic logic [OBS_W-1:0] quiet_obs(input logic rdy);
    return {rdy, {CS_W{1'b1}}, {ADDR_W{1'b0}}, 1'b0, 3'b000, 1'b0, 3'b000};
  endfunction

  // Expected drive cycle: write codes 010/110, read codes 011/111 (R5, R6, R7, R10)
  function automatic logic [OBS_W-1:0] drive_obs(input logic [CS_W-1:0] cs,
                                                 input logic [ADDR_W-1:0] a,
                                                 input logic [2:0] c);
    logic w, r;
    w = (c == 3'b010) || (c == 3'b110);
    r = (c == 3'b011) || (c == 3'b111);
    return {1'b0, ~cs, a, w, (w ? c : 3'b000), r, (r ? c : 3'b000)};
  endfunction

  task automatic check(input string tag, input logic [OBS_W-1:0] exp);
    logic [OBS_W-1:0] act;
    act = {req_ready, dfi_cs_n, dfi_addr, wr_en, wr_cmd, rd_en, rd_cmd};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Apply one command; if noisy, hammer the request and latency while busy (R8, R9).
  task automatic run_cmd(input logic [CS_W+ADDR_W+3+LAT_W-1:0] v, input bit noisy);
    logic [CS_W-1:0]   cs;
    logic [ADDR_W-1:0] a;
    logic [2:0]        c;
    logic [LAT_W-1:0]  l;
    {cs, a, c, l} = v;
    @(negedge clk);
    req_valid = 1'b1; req_cs = cs; req_addr = a; req_cmd = c; cfg_lat = l;
    @(posedge clk);
    for (int j = 0; j <= int'(l) + 1; j++) begin
      @(negedge clk);
      if (j == int'(l))
        check(noisy ? "R3 R8 R9 drive cycle" : "R3 R5 R6 R7 R10 drive cycle", drive_obs(cs, a, c));
      else if (j < int'(l))
        check(noisy ? "R2 R4 R8 waiting" : "R2 R4 waiting", quiet_obs(1'b0));
      else
        check("R2 R4 ready after drive", quiet_obs(1'b1));
      if (noisy && j < int'(l)) begin
        req_valid = 1'b1; req_cs = ~cs; req_addr = ~a; req_cmd = ~c;
        cfg_lat = (j % 2 == 0) ? '0 : '1;
      end else begin
        req_valid = 1'b0; req_cs = '0; req_addr = '0; req_cmd = '0;
      end
    end
    if (noisy) begin
      @(negedge clk);
      check("R8 no second command", quiet_obs(1'b1));
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 during reset", quiet_obs(1'b1));
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", quiet_obs(1'b1));

    // Table walk
    for (int i = 0; i < NVEC; i++) run_cmd(VEC[i], 1'b0);

    // R8, R9: busy-time request noise and latency changes
    run_cmd({2'b01, 14'h0BEE, 3'b010, 4'd4}, 1'b1);
    run_cmd({2'b10, 14'h1DAD, 3'b111, 4'd3}, 1'b1);

    // Back-to-back with valid held: second command accepted only when idle (R2)
    @(negedge clk);
    req_valid = 1'b1; req_cs = 2'b01; req_addr = 14'h0042; req_cmd = 3'b011; cfg_lat = 4'd0;
    @(negedge clk);
    check("R3 R6 first back-to-back", drive_obs(2'b01, 14'h0042, 3'b011));
    req_addr = 14'h0043;
    @(negedge clk);
    check("R2 ready between commands", quiet_obs(1'b1));
    @(negedge clk);
    check("R3 R6 second back-to-back", drive_obs(2'b01, 14'h0043, 3'b011));
    req_valid = 1'b0; req_addr = '0; req_cmd = '0; req_cs = '0;
    @(negedge clk);
    check("R4 idle after pair", quiet_obs(1'b1));

    // R1: reset while waiting cancels the command
    @(negedge clk);
    req_valid = 1'b1; req_cs = 2'b11; req_addr = 14'h0777; req_cmd = 3'b010; cfg_lat = 4'd5;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset mid-wait", quiet_obs(1'b1));
    rst = 1'b0;
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      check("R1 R4 no issue after reset", quiet_obs(1'b1));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule